// File: doc/BRIEF.md
# Pseudowire Receive Packet Validator

This block screens every received circuit-emulation pseudowire packet before its payload goes on to buffering. For each packet it takes the parsed 32-bit control word, the payload byte count and a one-cycle strobe, together with three settings that belong to the packet's bundle: a size-check enable, a conditioning-on-invalid enable and the expected payload length. One clock later it reports whether the packet is accepted, gives a reason code when the packet is dropped, and shows the packet's L-bit. Downstream logic uses that L-bit flag to replace the payload with conditioning data.

The decision depends on several inputs together. A packet whose type nibble is not zero is never treated as emulation traffic. A packet whose length differs from the expected value is dropped only when the size check is on and the packet is not exempt. A packet is exempt when its payload is flagged invalid and the bundle conditions invalid payloads. Accepted packets carry their 16-bit sequence number forward. Two saturating counters, one for each drop reason, keep a count of discards and can be cleared synchronously.

Top module: `pw_rx_validator`

## Requirements
- R1: A packet whose control word bits 31:28 are not all zero is discarded with reason code 1. A zero nibble passes this test.
- R2: With the size check on and the L-bit (control word bit 27) equal to 0, a packet whose byte count differs from the expected length is discarded with reason code 2.
- R3: With the size check on, the L-bit equal to 1 and conditioning-on-invalid on, the expected length is ignored and a length mismatch does not cause a discard.
- R4: With the size check on, the L-bit equal to 1 and conditioning-on-invalid off, a length mismatch still causes a discard with reason code 2.
- R5: With the size check off, no packet is discarded for its length, whatever the byte count.
- R6: When a packet has both a bad type nibble and a length mismatch, it reports reason code 1.
- R7: `dec_invalid` equals the L-bit of the decided packet, whether the packet is accepted or discarded.
- R8: `dec_valid` is high for exactly the one cycle after each strobe cycle. While `dec_valid` is low, `dec_accept`, `dec_reason`, `dec_invalid` and `dec_seq` are all zero.
- R9: The reason code is 0 for accepted, 1 for bad type and 2 for size mismatch. `dec_accept` is high exactly when a decision carries code 0.
- R10: `dec_seq` carries control word bits 15:0 for an accepted packet and is zero for a discarded one.
- R11: `cnt_type` and `cnt_size` each count the discards of their own reason. The count becomes visible in the same cycle as the decision, and each counter stops at 65535.
- R12: `cnt_clr` zeroes both counters at the next clock edge. It takes priority over an increment in the same cycle.
- R13: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_clr | input | 1 | Synchronous clear of both discard counters |
| pkt_valid | input | 1 | One-cycle strobe marking a packet on the inputs |
| ctrl_word | input | 32 | Parsed control word: type [31:28], L-bit [27], sequence [15:0] |
| pay_len | input | 11 | Payload byte count |
| cfg_size_chk | input | 1 | Bundle setting: verify payload length |
| cfg_cond_inv | input | 1 | Bundle setting: condition invalid payloads, which exempts them from the length check |
| cfg_exp_len | input | 11 | Bundle setting: expected payload byte count |
| dec_valid | output | 1 | Decision present |
| dec_accept | output | 1 | Packet accepted |
| dec_reason | output | 2 | 0 accepted, 1 bad type, 2 size mismatch |
| dec_invalid | output | 1 | Payload flagged invalid (L-bit) |
| dec_seq | output | 16 | Sequence number of an accepted packet |
| cnt_type | output | 16 | Saturating count of bad-type discards |
| cnt_size | output | 16 | Saturating count of size-mismatch discards |

## Verification
The decision register holds no state from one packet to the next, so a wrong classification or a stale value shows at the ports in the cycle right after the strobe. The tests pair each strobe with a check of the following cycle, and then check the idle cycle after it for leftover values. The counters do carry state. An increment that is missed or lands in the wrong counter shows in the same cycle as the decision, because the bench keeps its own expected counts. A saturation fault only shows after 65535 discards, so one test drives a long run of back-to-back strobes.

// File: rtl/pwv_pkg.sv
package pwv_pkg;

   typedef enum logic [1:0] {
      RSN_OK   = 2'd0,
      RSN_TYPE = 2'd1,
      RSN_SIZE = 2'd2
   } pwv_reason_e;

   localparam int CW_W      = 32;
   localparam int TYPE_MSB  = 31;
   localparam int TYPE_LSB  = 28;
   localparam int LBIT_POS  = 27;
   localparam int NUM_DISC  = 2;

endpackage

// File: rtl/pwv_classify.sv
module pwv_classify
   import pwv_pkg::*;
#(
   parameter int LEN_W = 11
) (
   input  logic [3:0]        type_nib,
   input  logic              lbit,
   input  logic [LEN_W-1:0]  pay_len,
   input  logic              cfg_size_chk,
   input  logic              cfg_cond_inv,
   input  logic [LEN_W-1:0]  cfg_exp_len,
   output pwv_reason_e       reason
);

   logic type_ok;
   logic size_exempt;
   logic size_bad;

   always_comb begin
      type_ok     = (type_nib == 4'h0);
      size_exempt = !cfg_size_chk || (lbit && cfg_cond_inv);
      size_bad    = !size_exempt && (pay_len != cfg_exp_len);
      if (!type_ok)
         reason = RSN_TYPE;
      else if (size_bad)
         reason = RSN_SIZE;
      else
         reason = RSN_OK;
   end

endmodule

// File: rtl/pwv_sat_cnt.sv
module pwv_sat_cnt #(
   parameter int W        = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          inc,
   output logic [W-1:0]  count
);

   localparam logic [W-1:0] TOP = {W{1'b1}};

   logic [W-1:0] nxt;

   generate
      if (SATURATE) begin : g_sat
         always_comb nxt = (count == TOP) ? count : count + W'(1);
      end else begin : g_wrap
         always_comb nxt = count + W'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (clr)
         count <= '0;
      else if (inc)
         count <= nxt;
   end

   AST_CNT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (count == '0)); // R12

   generate
      if (SATURATE) begin : g_sat_chk
         AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr && count == TOP) |=> (count == TOP)); // R11
      end
   endgenerate

endmodule

// File: rtl/pw_rx_validator.sv
module pw_rx_validator
   import pwv_pkg::*;
#(
   parameter int LEN_W = 11,
   parameter int CNT_W = 16,
   parameter int SEQ_W = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_clr,
   input  logic              pkt_valid,
   input  logic [31:0]       ctrl_word,
   input  logic [LEN_W-1:0]  pay_len,
   input  logic              cfg_size_chk,
   input  logic              cfg_cond_inv,
   input  logic [LEN_W-1:0]  cfg_exp_len,
   output logic              dec_valid,
   output logic              dec_accept,
   output logic [1:0]        dec_reason,
   output logic              dec_invalid,
   output logic [SEQ_W-1:0]  dec_seq,
   output logic [CNT_W-1:0]  cnt_type,
   output logic [CNT_W-1:0]  cnt_size
);

   generate
      if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len
         $error("LEN_W must lie in 1..16");
      end
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
         $error("CNT_W must lie in 2..32");
      end
      if (SEQ_W < 1 || SEQ_W > 16) begin : g_bad_seq
         $error("SEQ_W must lie in 1..16");
      end
   endgenerate

   logic [3:0]        type_nib;
   logic              lbit;
   logic [SEQ_W-1:0]  seq_in;
   pwv_reason_e       rsn_d;
   logic              unused_cw;

   assign type_nib  = ctrl_word[TYPE_MSB:TYPE_LSB];
   assign lbit      = ctrl_word[LBIT_POS];
   assign seq_in    = ctrl_word[SEQ_W-1:0];
   assign unused_cw = ^ctrl_word[LBIT_POS-1:SEQ_W];

   pwv_classify #(.LEN_W(LEN_W)) u_cls (
      .type_nib     (type_nib),
      .lbit         (lbit),
      .pay_len      (pay_len),
      .cfg_size_chk (cfg_size_chk),
      .cfg_cond_inv (cfg_cond_inv),
      .cfg_exp_len  (cfg_exp_len),
      .reason       (rsn_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_valid   <= 1'b0;
         dec_accept  <= 1'b0;
         dec_reason  <= 2'd0;
         dec_invalid <= 1'b0;
         dec_seq     <= '0;
      end else begin
         dec_valid <= pkt_valid;
         if (pkt_valid) begin
            dec_reason  <= rsn_d;
            dec_accept  <= (rsn_d == RSN_OK);
            dec_invalid <= lbit;
            dec_seq     <= (rsn_d == RSN_OK) ? seq_in : '0;
         end else begin
            dec_reason  <= 2'd0;
            dec_accept  <= 1'b0;
            dec_invalid <= 1'b0;
            dec_seq     <= '0;
         end
      end
   end

   logic [CNT_W-1:0] cnt_arr [NUM_DISC];

   generate
      for (genvar g = 0; g < NUM_DISC; g++) begin : g_cnt
         localparam logic [1:0] CODE = 2'(g + 1);
         pwv_sat_cnt #(.W(CNT_W), .SATURATE(SATURATE)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (cnt_clr),
            .inc   (pkt_valid && (rsn_d == pwv_reason_e'(CODE))),
            .count (cnt_arr[g])
         );
      end
   endgenerate

   assign cnt_type = cnt_arr[0];
   assign cnt_size = cnt_arr[1];

   AST_TYPE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && ctrl_word[31:28] != 4'h0) |=>
      (dec_valid && !dec_accept && dec_reason == 2'd1)); // R1

   AST_SIZE_L0: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && ctrl_word[31:28] == 4'h0 && cfg_size_chk && !ctrl_word[27]
       && pay_len != cfg_exp_len) |=> (dec_reason == 2'd2)); // R2

   AST_COND_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && ctrl_word[31:28] == 4'h0 && cfg_size_chk && ctrl_word[27]
       && cfg_cond_inv) |=> dec_accept); // R3

   AST_SIZE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && ctrl_word[31:28] == 4'h0 && !cfg_size_chk) |=> dec_accept); // R5

   AST_INVALID_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid |=> (dec_invalid == $past(ctrl_word[27]))); // R7

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !pkt_valid |=> (!dec_valid && !dec_accept && dec_reason == 2'd0
                      && !dec_invalid && dec_seq == '0)); // R8

   AST_ACCEPT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      dec_accept |-> (dec_valid && dec_reason == 2'd0)); // R9

endmodule

// File: tb/sim_pw_rx_validator.sv
module sim_pw_rx_validator;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cnt_clr = 1'b0;
   logic        pkt_valid = 1'b0;
   logic [31:0] ctrl_word = '0;
   logic [10:0] pay_len = '0;
   logic        cfg_size_chk = 1'b0;
   logic        cfg_cond_inv = 1'b0;
   logic [10:0] cfg_exp_len = '0;
   logic        dec_valid, dec_accept, dec_invalid;
   logic [1:0]  dec_reason;
   logic [15:0] dec_seq, cnt_type, cnt_size;

   int n_checks = 0;
   int n_err = 0;
   int exp_type = 0;
   int exp_size = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pw_rx_validator u0 (
      .clk(clk), .rst_n(rst_n), .cnt_clr(cnt_clr), .pkt_valid(pkt_valid),
      .ctrl_word(ctrl_word), .pay_len(pay_len), .cfg_size_chk(cfg_size_chk),
      .cfg_cond_inv(cfg_cond_inv), .cfg_exp_len(cfg_exp_len),
      .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_reason(dec_reason),
      .dec_invalid(dec_invalid), .dec_seq(dec_seq),
      .cnt_type(cnt_type), .cnt_size(cnt_size)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // one packet; checks the decision cycle and the quiet cycle after it
   task automatic send(input string req, input logic [31:0] cw, input int len,
                       input bit szc, input bit cond, input int elen,
                       input int exp_rsn);
      @(negedge clk);
      ctrl_word = cw; pay_len = 11'(len); cfg_size_chk = szc;
      cfg_cond_inv = cond; cfg_exp_len = 11'(elen); pkt_valid = 1'b1;
      @(posedge clk); #1;
      if (exp_rsn == 1) exp_type++;
      if (exp_rsn == 2) exp_size++;
      chk({req, " valid"}, int'(dec_valid), 1);
      chk({req, " reason"}, int'(dec_reason), exp_rsn);
      chk({req, " accept R9"}, int'(dec_accept), int'(exp_rsn == 0));
      chk({req, " invalid R7"}, int'(dec_invalid), int'(cw[27]));
      chk({req, " seq R10"}, int'(dec_seq), (exp_rsn == 0) ? int'(cw[15:0]) : 0);
      chk({req, " cnt_type R11"}, int'(cnt_type), exp_type);
      chk({req, " cnt_size R11"}, int'(cnt_size), exp_size);
      @(negedge clk);
      pkt_valid = 1'b0;
      @(posedge clk); #1;
      chk({req, " idle valid R8"}, int'(dec_valid), 0);
      chk({req, " idle outputs R8"},
          int'(dec_accept) + int'(dec_reason) + int'(dec_invalid) + int'(dec_seq), 0);
   endtask

   task automatic t_reset();
      chk("R13 dec_valid", int'(dec_valid), 0);
      chk("R13 outputs", int'(dec_accept) + int'(dec_reason) + int'(dec_invalid)
          + int'(dec_seq), 0);
      chk("R13 counters", int'(cnt_type) + int'(cnt_size), 0);
   endtask

   task automatic t_type();
      send("R1 nibble 1", 32'h1000_1234, 40, 1'b0, 1'b0, 40, 1);
      send("R1 nibble F", 32'hF000_0001, 40, 1'b0, 1'b0, 40, 1);
      send("R1 nibble 0", 32'h0000_ABCD, 40, 1'b0, 1'b0, 40, 0);
   endtask

   task automatic t_size();
      send("R2 mismatch", 32'h0000_0011, 64, 1'b1, 1'b0, 60, 2);
      send("R2 match", 32'h0000_0012, 60, 1'b1, 1'b0, 60, 0);
      send("R2 cond on L0", 32'h0000_0013, 61, 1'b1, 1'b1, 60, 2);
      send("R3 exempt", 32'h0800_0014, 7, 1'b1, 1'b1, 60, 0);
      send("R4 no cond", 32'h0800_0015, 7, 1'b1, 1'b0, 60, 2);
      send("R5 off L0", 32'h0000_0016, 2047, 1'b0, 1'b0, 0, 0);
      send("R5 off L1", 32'h0800_FFFF, 1, 1'b0, 1'b0, 300, 0);
      send("R6 both bad", 32'h2000_0017, 9, 1'b1, 1'b0, 60, 1);
   endtask

   task automatic t_back2back();
      @(negedge clk);
      ctrl_word = 32'h0000_0101; pay_len = 11'd8; cfg_size_chk = 1'b1;
      cfg_cond_inv = 1'b0; cfg_exp_len = 11'd8; pkt_valid = 1'b1;
      @(posedge clk); #1;
      chk("R8 b2b first", int'(dec_seq), 32'h0101);
      @(negedge clk);
      ctrl_word = 32'h0000_0102; pay_len = 11'd9;
      @(posedge clk); #1;
      exp_size++;
      chk("R8 b2b second valid", int'(dec_valid), 1);
      chk("R8 b2b second reason", int'(dec_reason), 2);
      @(negedge clk);
      pkt_valid = 1'b0;
      @(posedge clk); #1;
      chk("R8 b2b idle", int'(dec_valid), 0);
      chk("R11 b2b cnt_size", int'(cnt_size), exp_size);
   endtask

   task automatic t_clear();
      @(negedge clk);
      ctrl_word = 32'h3000_0000; pkt_valid = 1'b1; cnt_clr = 1'b1;
      @(posedge clk); #1;
      chk("R12 clear wins type", int'(cnt_type), 0);
      chk("R12 clear size", int'(cnt_size), 0);
      @(negedge clk);
      pkt_valid = 1'b0; cnt_clr = 1'b0;
      exp_type = 0; exp_size = 0;
      @(posedge clk); #1;
      chk("R12 stays zero", int'(cnt_type) + int'(cnt_size), 0);
   endtask

   task automatic t_saturate();
      @(negedge clk);
      ctrl_word = 32'h4000_0000; pkt_valid = 1'b1;
      repeat (65540) @(posedge clk);
      #1;
      chk("R11 saturate", int'(cnt_type), 65535);
      chk("R11 other untouched", int'(cnt_size), 0);
      @(negedge clk);
      pkt_valid = 1'b0;
      @(posedge clk); #1;
      chk("R11 holds", int'(cnt_type), 65535);
   endtask

   initial begin
      #1;
      t_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;
      t_reset();
      t_type();
      t_size();
      t_back2back();
      t_clear();
      t_saturate();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_err++;
         $display("FAIL watchdog R8: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
         $finish;
      end
   end

endmodule